// File: doc/BRIEF.md
# I2C Master Command and Receive Queue

This block sits between the register port of an I2C master and its protocol engine. Software writes 9-bit entries through one data/command register. Each entry is either a byte to transmit or a request to receive one byte. The engine takes these entries in order. The engine also hands received bytes back, and software reads them out of the same register.

Software can read the occupancy of both queues. Two programmable thresholds turn those occupancy counts into a "transmit queue running low" flag and a "receive data ready" flag. Misuse of either queue produces a one-cycle error pulse. A transfer abort, or taking the controller out of its enabled state, empties both queues at once.

Top module: `i2c_cmd_queue`

## Requirements
- R1: A register write to address 0x10 queues the entry {wdata[8], wdata[7:0]}. Bit 8 set means a read request and bit 8 clear means a write of the byte. When the queue is not empty, the oldest entry is shown on `eng_cmd_word` with `eng_cmd_valid` high. `eng_cmd_take` removes that entry, and entries leave in the order they were written.
- R2: A register read of address 0x10 returns the oldest received byte in bits 7:0, with the other bits zero. The read removes that byte, and received bytes come out in the order the engine delivered them.
- R3: A register read of 0x74 returns the number of entries in the transmit queue. A register read of 0x78 returns the number of bytes in the receive queue. Both counts range from 0 to DEPTH.
- R4: `tx_low` is high exactly while the transmit count is less than or equal to the transmit threshold. That threshold is written and read back at 0x3C.
- R5: `rx_ready` is high exactly while the receive count is strictly greater than the receive threshold. That threshold is written and read back at 0x38. A threshold of 0 therefore flags a single byte.
- R6: A cycle with `eng_abort` high empties both queues. Both counts read 0 afterwards and `eng_cmd_valid` is low.
- R7: A write to 0x10 while the transmit queue holds DEPTH entries changes nothing in the queue. It raises `tx_over` for the single cycle after the write.
- R8: A read of 0x10 with the receive queue empty returns 0 and raises `rx_under` for one cycle. An engine push into a full receive queue drops the byte and raises `rx_over` for one cycle.
- R9: While `ctrl_en` is low, both queues are held empty. Data-register writes and engine pushes are ignored and raise no error pulse.
- R10: A register read of 0xF4 returns DEPTH-1. After reset, both counts and both thresholds are 0 and all error pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ctrl_en | input | 1 | Controller enable; low flushes and holds both queues |
| reg_addr | input | 8 | Register byte address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a read of 0x10 pops) |
| reg_wdata | input | 9 | Register write data |
| reg_rdata | output | 16 | Register read data, valid in the cycle of `reg_rd` |
| eng_cmd_valid | output | 1 | Transmit queue holds an entry |
| eng_cmd_word | output | 9 | Oldest entry: bit 8 read request, bits 7:0 byte |
| eng_cmd_take | input | 1 | Engine removes the oldest entry |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_byte | input | 8 | Received byte |
| eng_abort | input | 1 | Transfer abort; empties both queues |
| tx_low | output | 1 | Transmit count at or below its threshold |
| rx_ready | output | 1 | Receive count above its threshold |
| tx_over | output | 1 | One-cycle pulse: write into a full transmit queue |
| rx_over | output | 1 | One-cycle pulse: push into a full receive queue |
| rx_under | output | 1 | One-cycle pulse: read of an empty receive queue |

## Verification
The bench builds the block with DEPTH = 4, so counts take only the values 0 to 4. That small range lets every threshold value be crossed with every fill level on both queues, and the flag expected at each point is just a comparison done in the bench. The same depth makes the full and empty boundaries quick to reach. Overflow, underflow, abort and disable are each exercised there, and entry order is checked across pointer wrap-around.

// File: rtl/i2c_cq_pkg.sv
package i2c_cq_pkg;
    localparam logic [7:0] ADR_DATA   = 8'h10;
    localparam logic [7:0] ADR_RX_THR = 8'h38;
    localparam logic [7:0] ADR_TX_THR = 8'h3C;
    localparam logic [7:0] ADR_TX_LVL = 8'h74;
    localparam logic [7:0] ADR_RX_LVL = 8'h78;
    localparam logic [7:0] ADR_DEPTH  = 8'hF4;
    localparam int         CMD_W      = 9;
    localparam int         BYTE_W     = 8;
    localparam int         RDATA_W    = 16;
endpackage

// File: rtl/cq_fifo.sv
module cq_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [W-1:0]                 push_data,
    input  logic                         pop,
    output logic [W-1:0]                 head,
    output logic [$clog2(DEPTH+1)-1:0]   level,
    output logic                         empty,
    output logic                         over,
    output logic                         under
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [DEPTH-1:0][W-1:0] mem;
        logic [PW-1:0]           wp;
        logic [PW-1:0]           rp;
        logic [LW-1:0]           cnt;
        logic                    over;
        logic                    under;
    } st_t;

    st_t  s_d, s_q;
    logic full_w, empty_w, do_push, do_pop;

    function automatic logic [PW-1:0] ptr_next(input logic [PW-1:0] p);
        return (p == PW'(DEPTH-1)) ? '0 : p + PW'(1);
    endfunction

    assign full_w  = (s_q.cnt == LW'(DEPTH));
    assign empty_w = (s_q.cnt == '0);
    assign do_push = push && !full_w && !flush;
    assign do_pop  = pop && !empty_w && !flush;

    always_comb begin
        s_d       = s_q;
        s_d.over  = push && full_w && !flush;
        s_d.under = pop && empty_w && !flush;
        if (flush) begin
            s_d.wp  = '0;
            s_d.rp  = '0;
            s_d.cnt = '0;
        end else begin
            if (do_push) begin
                s_d.mem[s_q.wp] = push_data;
                s_d.wp          = ptr_next(s_q.wp);
            end
            if (do_pop) begin
                s_d.rp = ptr_next(s_q.rp);
            end
            s_d.cnt = s_q.cnt + LW'(do_push) - LW'(do_pop);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign head  = s_q.mem[s_q.rp];
    assign level = s_q.cnt;
    assign empty = empty_w;
    assign over  = s_q.over;
    assign under = s_q.under;

    a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH));
    a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (level == '0));
    a_r7_full_push_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full_w && !flush && !pop) |=> (over && $stable(level)));
    a_r8_empty_pop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty_w && !flush && !push) |=> (under && level == '0));
endmodule

// File: rtl/cq_thresh.sv
module cq_thresh #(
    parameter int LW    = 4,
    parameter bit ABOVE = 1'b0
) (
    input  logic [LW-1:0] lvl,
    input  logic [LW-1:0] thr,
    output logic          hit
);
    generate
        if (ABOVE) begin : g_above
            assign hit = (lvl > thr);
        end else begin : g_at_or_below
            assign hit = (lvl <= thr);
        end
    endgenerate
endmodule

// File: rtl/i2c_cmd_queue.sv
module i2c_cmd_queue
    import i2c_cq_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctrl_en,
    input  logic [7:0]         reg_addr,
    input  logic               reg_wr,
    input  logic               reg_rd,
    input  logic [CMD_W-1:0]   reg_wdata,
    output logic [RDATA_W-1:0] reg_rdata,
    output logic               eng_cmd_valid,
    output logic [CMD_W-1:0]   eng_cmd_word,
    input  logic               eng_cmd_take,
    input  logic               eng_rx_push,
    input  logic [BYTE_W-1:0]  eng_rx_byte,
    input  logic               eng_abort,
    output logic               tx_low,
    output logic               rx_ready,
    output logic               tx_over,
    output logic               rx_over,
    output logic               rx_under
);
    localparam int LW = $clog2(DEPTH+1);

    typedef struct packed {
        logic [LW-1:0] tx_thr;
        logic [LW-1:0] rx_thr;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    logic              flush_all, tx_push, rx_pop, tx_pop, rx_push;
    logic [LW-1:0]     tx_lvl, rx_lvl;
    logic              tx_empty, rx_empty;
    logic [BYTE_W-1:0] rx_head;
    logic              tx_under_unused, rx_over_int;

    assign flush_all = eng_abort || !ctrl_en;
    assign tx_push   = ctrl_en && reg_wr && (reg_addr == ADR_DATA);
    assign rx_pop    = ctrl_en && reg_rd && (reg_addr == ADR_DATA);
    assign tx_pop    = ctrl_en && eng_cmd_take;
    assign rx_push   = ctrl_en && eng_rx_push;

    always_comb begin
        cfg_d = cfg_q;
        if (reg_wr && reg_addr == ADR_TX_THR) cfg_d.tx_thr = reg_wdata[LW-1:0];
        if (reg_wr && reg_addr == ADR_RX_THR) cfg_d.rx_thr = reg_wdata[LW-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    cq_fifo #(.W(CMD_W), .DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .push(tx_push), .push_data(reg_wdata), .pop(tx_pop),
        .head(eng_cmd_word), .level(tx_lvl), .empty(tx_empty),
        .over(tx_over), .under(tx_under_unused)
    );

    cq_fifo #(.W(BYTE_W), .DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(flush_all),
        .push(rx_push), .push_data(eng_rx_byte), .pop(rx_pop),
        .head(rx_head), .level(rx_lvl), .empty(rx_empty),
        .over(rx_over_int), .under(rx_under)
    );

    assign rx_over       = rx_over_int;
    assign eng_cmd_valid = !tx_empty;

    cq_thresh #(.LW(LW), .ABOVE(1'b0)) u_txcmp (
        .lvl(tx_lvl), .thr(cfg_q.tx_thr), .hit(tx_low));
    cq_thresh #(.LW(LW), .ABOVE(1'b1)) u_rxcmp (
        .lvl(rx_lvl), .thr(cfg_q.rx_thr), .hit(rx_ready));

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADR_DATA:   reg_rdata = rx_empty ? '0 : RDATA_W'(rx_head);
            ADR_TX_THR: reg_rdata = RDATA_W'(cfg_q.tx_thr);
            ADR_RX_THR: reg_rdata = RDATA_W'(cfg_q.rx_thr);
            ADR_TX_LVL: reg_rdata = RDATA_W'(tx_lvl);
            ADR_RX_LVL: reg_rdata = RDATA_W'(rx_lvl);
            ADR_DEPTH:  reg_rdata = RDATA_W'(DEPTH-1);
            default:    reg_rdata = '0;
        endcase
    end

    a_r9_disabled_holds_empty: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_en |=> (tx_lvl == '0 && rx_lvl == '0 && !tx_over && !rx_over));
    a_r6_abort_drops_valid: assert property (@(posedge clk) disable iff (!rst_n)
        eng_abort |=> !eng_cmd_valid);
    a_r8_flags_exclusive_under: assert property (@(posedge clk) disable iff (!rst_n)
        rx_under |-> (rx_lvl == '0));
    a_r1_write_adds_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_push && !eng_abort && !tx_pop && tx_lvl < LW'(DEPTH)) |=> (tx_lvl == $past(tx_lvl) + LW'(1)));
endmodule

// File: tb/i2c_cmd_queue_tb.sv
`timescale 1ns/1ps
module i2c_cmd_queue_tb_top;
    localparam int DEPTH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_en = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_wdata = '0;
    logic [15:0] reg_rdata;
    logic        eng_cmd_valid;
    logic [8:0]  eng_cmd_word;
    logic        eng_cmd_take = 1'b0, eng_rx_push = 1'b0, eng_abort = 1'b0;
    logic [7:0]  eng_rx_byte = '0;
    logic        tx_low, rx_ready, tx_over, rx_over, rx_under;

    int total = 0, bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    i2c_cmd_queue #(.DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en),
        .reg_addr(reg_addr), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_cmd_valid(eng_cmd_valid), .eng_cmd_word(eng_cmd_word),
        .eng_cmd_take(eng_cmd_take), .eng_rx_push(eng_rx_push),
        .eng_rx_byte(eng_rx_byte), .eng_abort(eng_abort),
        .tx_low(tx_low), .rx_ready(rx_ready),
        .tx_over(tx_over), .rx_over(rx_over), .rx_under(rx_under)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [8:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 v = int'(reg_rdata);
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic take(output int w, output bit vld);
        @(negedge clk);
        w = int'(eng_cmd_word); vld = eng_cmd_valid;
        eng_cmd_take = 1'b1;
        @(negedge clk);
        eng_cmd_take = 1'b0;
    endtask

    task automatic rx_in(input logic [7:0] b);
        @(negedge clk);
        eng_rx_byte = b; eng_rx_push = 1'b1;
        @(negedge clk);
        eng_rx_push = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        int v, w;
        bit vld;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        rd(8'h74, v); chk(v == 0, "R10 tx level", v, 0);
        rd(8'h78, v); chk(v == 0, "R10 rx level", v, 0);
        rd(8'h3C, v); chk(v == 0, "R10 tx thr", v, 0);
        rd(8'h38, v); chk(v == 0, "R10 rx thr", v, 0);
        rd(8'hF4, v); chk(v == DEPTH-1, "R10 depth", v, DEPTH-1);
        chk(!tx_over && !rx_over && !rx_under, "R10 flags", int'(tx_over), 0);
        chk(tx_low == 1'b1, "R4 reset tx_low", int'(tx_low), 1);
        chk(rx_ready == 1'b0, "R5 reset rx_ready", int'(rx_ready), 0);
        // R9 disabled: writes ignored
        wr(8'h10, 9'h055);
        chk(!tx_over, "R9 no flag", int'(tx_over), 0);
        rd(8'h74, v); chk(v == 0, "R9 tx ignored", v, 0);
        rx_in(8'h11);
        rd(8'h78, v); chk(v == 0, "R9 rx ignored", v, 0);
        ctrl_en = 1'b1;

        // TX sweep: R1 R3 R4 R7
        for (int thr = 0; thr <= DEPTH; thr++) begin
            wr(8'h3C, 9'(thr));
            rd(8'h3C, v); chk(v == thr, "R4 thr readback", v, thr);
            chk(tx_low == (0 <= thr), "R4 tx_low empty", int'(tx_low), 1);
            for (int n = 1; n <= DEPTH; n++) begin
                wr(8'h10, {1'(n % 2), 8'(thr * 16 + n)});
                rd(8'h74, v); chk(v == n, "R3 tx level", v, n);
                chk(tx_low == (n <= thr), "R4 tx_low", int'(tx_low), int'(n <= thr));
                chk(!tx_over, "R7 no overflow", int'(tx_over), 0);
            end
            wr(8'h10, 9'h1FF);
            chk(tx_over, "R7 overflow pulse", int'(tx_over), 1);
            rd(8'h74, v); chk(v == DEPTH, "R7 level kept", v, DEPTH);
            chk(!tx_over, "R7 pulse one cycle", int'(tx_over), 0);
            for (int n = 1; n <= DEPTH; n++) begin
                take(w, vld);
                chk(vld && w == int'({1'(n % 2), 8'(thr * 16 + n)}), "R1 order",
                    w, int'({1'(n % 2), 8'(thr * 16 + n)}));
            end
            chk(!eng_cmd_valid, "R7 dropped entry absent", int'(eng_cmd_valid), 0);
        end

        // RX sweep: R2 R3 R5 R8
        for (int thr = 0; thr <= DEPTH; thr++) begin
            wr(8'h38, 9'(thr));
            chk(rx_ready == 1'b0, "R5 empty", int'(rx_ready), 0);
            for (int n = 1; n <= DEPTH; n++) begin
                rx_in(8'(8'hA0 + thr * 8 + n));
                chk(!rx_over, "R8 no overflow", int'(rx_over), 0);
                rd(8'h78, v); chk(v == n, "R3 rx level", v, n);
                chk(rx_ready == (n > thr), "R5 rx_ready", int'(rx_ready), int'(n > thr));
            end
            rx_in(8'h00);
            chk(rx_over, "R8 rx overflow pulse", int'(rx_over), 1);
            for (int n = 1; n <= DEPTH; n++) begin
                rd(8'h10, v);
                chk(v == 8'hA0 + thr * 8 + n, "R2 rx order", v, 8'hA0 + thr * 8 + n);
            end
            chk(!rx_under, "R8 no underflow", int'(rx_under), 0);
            rd(8'h10, v);
            chk(v == 0, "R8 empty read zero", v, 0);
            chk(rx_under, "R8 underflow pulse", int'(rx_under), 1);
        end

        // R6 abort
        wr(8'h10, 9'h101); wr(8'h10, 9'h002); wr(8'h10, 9'h003);
        rx_in(8'h31); rx_in(8'h32);
        @(negedge clk); eng_abort = 1'b1;
        @(negedge clk); eng_abort = 1'b0;
        rd(8'h74, v); chk(v == 0, "R6 tx flushed", v, 0);
        rd(8'h78, v); chk(v == 0, "R6 rx flushed", v, 0);
        chk(!eng_cmd_valid, "R6 valid low", int'(eng_cmd_valid), 0);
        // queues work after abort
        wr(8'h10, 9'h077);
        take(w, vld); chk(vld && w == 9'h077, "R6 reuse", w, 9'h077);

        // R9 disable flush
        wr(8'h10, 9'h044); rx_in(8'h45);
        @(negedge clk); ctrl_en = 1'b0;
        @(negedge clk);
        rd(8'h74, v); chk(v == 0, "R9 tx flushed", v, 0);
        rd(8'h78, v); chk(v == 0, "R9 rx flushed", v, 0);
        ctrl_en = 1'b1;
        rd(8'h10, v); chk(v == 0, "R9 nothing left", v, 0);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule